// File: doc/BRIEF.md
# Address Break Match Controller

This block watches the processor bus and raises a break interrupt request when a bus cycle hits a programmed condition. It has two identical channels. Each channel holds a 24-bit break address and an 8-bit control word. The control word chooses the kind of access to catch: an instruction fetch, a data read, a data write, or either data access. It also chooses which bus master the cycle must come from, and it can widen the compare by ignoring the low address bits.

A match sets a sticky flag in the control word. The flag stays set until software writes a 0 to it. The interrupt request for a channel is the flag gated by the channel's enable bit, and it is taken from a register. On a fetch match, the flag and the request both rise on the clock edge that ends the matching bus cycle, which is before the fetched instruction can execute. The flag is also set while the enable bit is 0, so software can poll for matches without taking an interrupt.

Top module: `addr_break_unit`

## Requirements
- R1: After synchronous reset, all four registers read 0 and both interrupt requests are 0.
- R2: The register port maps `reg_addr` 0 to the channel A break address, 1 to channel A control, 2 to the channel B break address and 3 to channel B control. A write takes effect at the clock edge. Reads are combinational. The break address holds all 24 bits, and control bits 6:0 read back as written.
- R3: Control layout: bit 0 is the interrupt enable, bits 2:1 the condition, bits 5:3 the mask code, bit 6 the master select and bit 7 the match flag. Condition 00 matches an instruction fetch (`mon_fetch`) whose address equals the break address. The flag and the request become visible on the clock edge that ends that bus cycle.
- R4: Condition 01 matches a data read (`mon_read`), 10 matches a data write (`mon_write`) and 11 matches either. A fetch never satisfies conditions 01 to 11.
- R5: A cycle matches only when `mon_master` equals control bit 6. The value 0 denotes the CPU.
- R6: The mask code sets how many low address bits the compare ignores: 0 ignores none, codes 1, 2, 3 and 4 ignore 1, 2, 4 and 8 bits, and codes 5, 6 and 7 ignore 12, 16 and 24 bits.
- R7: The flag is sticky. A control write with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it as it was. A match in the same cycle as a clearing write leaves the flag set.
- R8: A match sets the flag even when the enable bit is 0. The request equals the flag AND the enable bit, updated at the same edge as the flag.
- R9: The channels are independent. A match or a write on one channel changes nothing on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data (control is zero-extended) |
| mon_addr | input | 24 | Address of the monitored bus cycle |
| mon_master | input | 1 | Bus master of the cycle (0 = CPU) |
| mon_fetch | input | 1 | Cycle is an instruction fetch |
| mon_read | input | 1 | Cycle is a data read |
| mon_write | input | 1 | Cycle is a data write |
| break_irq | output | 2 | Break interrupt request, bit 0 = channel A, bit 1 = channel B |

## Verification
Several properties are checked on every cycle:
- a request never appears without the enable bit and the flag;
- the flag never falls except after a control write that clears it;
- an exact fetch match under condition 00 always sets the flag on the next edge;
- both requests are low right after reset.

Other behaviours depend on chosen register values and stimulus, so only the bench scenarios can show them:
- the mask-width decoding;
- read, write and either-access selection;
- master filtering;
- the set-wins-over-clear collision;
- channel independence.

The bench covers these with directed cases and with a random run checked against a reference model.

// File: rtl/abrk_pkg.sv
package abrk_pkg;

    localparam int ABRK_AW   = 24;
    localparam int ABRK_CW   = 8;
    localparam int ABRK_NCH  = 2;

    typedef enum logic [1:0] {
        COND_FETCH = 2'b00,
        COND_READ  = 2'b01,
        COND_WRITE = 2'b10,
        COND_DATA  = 2'b11
    } cond_e;

    // packed from bit 7 down to bit 0
    typedef struct packed {
        logic       flag;
        logic       master_sel;
        logic [2:0] mask_code;
        cond_e      cond;
        logic       irq_en;
    } ctrl_t;

    typedef struct packed {
        logic fetch;
        logic rd;
        logic wr;
        logic master;
    } bus_kind_t;

    // number of low address bits left out of the compare
    function automatic int unsigned mask_width(input logic [2:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 1;
            3'd2:    return 2;
            3'd3:    return 4;
            3'd4:    return 8;
            3'd5:    return 12;
            3'd6:    return 16;
            default: return 24;
        endcase
    endfunction

    function automatic logic cond_hit(input cond_e c, input bus_kind_t k);
        case (c)
            COND_FETCH: return k.fetch;
            COND_READ:  return k.rd;
            COND_WRITE: return k.wr;
            default:    return k.rd | k.wr;
        endcase
    endfunction

endpackage

// File: rtl/abrk_match.sv
module abrk_match
    import abrk_pkg::*;
#(
    parameter int ADDR_W = ABRK_AW
) (
    input  ctrl_t              ctrl,
    input  logic [ADDR_W-1:0]  bar,
    input  logic [ADDR_W-1:0]  mon_addr,
    input  bus_kind_t          kind,
    output logic               hit
);
    logic [ADDR_W-1:0] ones;
    logic [ADDR_W-1:0] care;
    logic              addr_eq;
    logic              kind_ok;
    logic              master_ok;

    always_comb begin
        ones      = '1;
        care      = ones << mask_width(ctrl.mask_code);
        addr_eq   = ((bar ^ mon_addr) & care) == '0;
        kind_ok   = cond_hit(ctrl.cond, kind);
        master_ok = (kind.master == ctrl.master_sel);
        hit       = addr_eq & kind_ok & master_ok;
    end
endmodule

// File: rtl/abrk_channel.sv
module abrk_channel
    import abrk_pkg::*;
#(
    parameter int ADDR_W = ABRK_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bar_we,
    input  logic               ctrl_we,
    input  logic [ADDR_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]  mon_addr,
    input  bus_kind_t          kind,
    output logic [ADDR_W-1:0]  bar_q,
    output ctrl_t              ctrl_q,
    output logic               irq
);
    logic  hit;
    ctrl_t ctrl_d;

    abrk_match #(.ADDR_W(ADDR_W)) u_match (
        .ctrl     (ctrl_q),
        .bar      (bar_q),
        .mon_addr (mon_addr),
        .kind     (kind),
        .hit      (hit)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we) begin
            ctrl_d.irq_en     = wdata[0];
            ctrl_d.cond       = cond_e'(wdata[2:1]);
            ctrl_d.mask_code  = wdata[5:3];
            ctrl_d.master_sel = wdata[6];
            // writing 1 keeps the flag, writing 0 clears it
            ctrl_d.flag       = ctrl_q.flag & wdata[7];
        end
        // a match wins over a clearing write
        if (hit) ctrl_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bar_q  <= '0;
            ctrl_q <= '0;
            irq    <= 1'b0;
        end else begin
            if (bar_we) bar_q <= wdata;
            ctrl_q <= ctrl_d;
            irq    <= ctrl_d.flag & ctrl_d.irq_en;
        end
    end
endmodule

// File: rtl/addr_break_unit.sv
module addr_break_unit
    import abrk_pkg::*;
#(
    parameter int ADDR_W = ABRK_AW,
    parameter int NUM_CH = ABRK_NCH,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int RA_W  = CH_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [RA_W-1:0]    reg_addr,
    input  logic [ADDR_W-1:0]  reg_wdata,
    output logic [ADDR_W-1:0]  reg_rdata,
    input  logic [ADDR_W-1:0]  mon_addr,
    input  logic               mon_master,
    input  logic               mon_fetch,
    input  logic               mon_read,
    input  logic               mon_write,
    output logic [NUM_CH-1:0]  break_irq
);
    bus_kind_t                          kind;
    logic [NUM_CH-1:0][ADDR_W-1:0]      bar_flat;
    logic [NUM_CH-1:0][ABRK_CW-1:0]     ctrl_flat;
    logic [CH_W-1:0]                    sel_ch;

    assign kind   = '{fetch: mon_fetch, rd: mon_read, wr: mon_write, master: mon_master};
    assign sel_ch = reg_addr[RA_W-1:1];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ctrl_t ctrl_q;
        logic  bar_we;
        logic  ctrl_we;

        assign bar_we  = reg_we && (reg_addr == RA_W'(2 * i));
        assign ctrl_we = reg_we && (reg_addr == RA_W'(2 * i + 1));

        abrk_channel #(.ADDR_W(ADDR_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .bar_we   (bar_we),
            .ctrl_we  (ctrl_we),
            .wdata    (reg_wdata),
            .mon_addr (mon_addr),
            .kind     (kind),
            .bar_q    (bar_flat[i]),
            .ctrl_q   (ctrl_q),
            .irq      (break_irq[i])
        );

        assign ctrl_flat[i] = ctrl_q;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[0]) reg_rdata[ABRK_CW-1:0] = ctrl_flat[sel_ch];
        else             reg_rdata              = bar_flat[sel_ch];
    end
endmodule

// File: rtl/abrk_checker.sv
module abrk_checker #(
    parameter int ADDR_W = 24,
    parameter int NUM_CH = 2,
    parameter int RA_W   = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          reg_we,
    input logic [RA_W-1:0]               reg_addr,
    input logic [ADDR_W-1:0]             reg_wdata,
    input logic [ADDR_W-1:0]             mon_addr,
    input logic                          mon_master,
    input logic                          mon_fetch,
    input logic [NUM_CH-1:0]             break_irq,
    input logic [NUM_CH-1:0][ADDR_W-1:0] bar_flat,
    input logic [NUM_CH-1:0][7:0]        ctrl_flat
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> break_irq == '0);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
            !ctrl_flat[i][0] |-> !break_irq[i]);

        assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
            break_irq[i] |-> ctrl_flat[i][7]);

        assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
            (ctrl_flat[i][7] &&
             !(reg_we && reg_addr == RA_W'(2 * i + 1) && !reg_wdata[7]))
            |=> ctrl_flat[i][7]);

        assert_fetch_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
            (mon_fetch && mon_addr == bar_flat[i] && ctrl_flat[i][2:1] == 2'b00 &&
             mon_master == ctrl_flat[i][6])
            |=> ctrl_flat[i][7]);
    end
endmodule

bind addr_break_unit abrk_checker #(
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH),
    .RA_W   (RA_W)
) u_abrk_checker (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .mon_addr   (mon_addr),
    .mon_master (mon_master),
    .mon_fetch  (mon_fetch),
    .break_irq  (break_irq),
    .bar_flat   (bar_flat),
    .ctrl_flat  (ctrl_flat)
);

// File: tb/sim_addr_break_unit.sv
`timescale 1ns/1ps
module sim_addr_break_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic [23:0] mon_addr = '0;
    logic        mon_master = 1'b0;
    logic        mon_fetch = 1'b0;
    logic        mon_read = 1'b0;
    logic        mon_write = 1'b0;
    logic [1:0]  break_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    logic [23:0] m_bar  [2];
    logic [6:0]  m_ctrl [2];
    logic        m_flag [2];
    logic        m_irq  [2];

    always #10 clk = ~clk;

    addr_break_unit u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_addr(mon_addr),
        .mon_master(mon_master), .mon_fetch(mon_fetch), .mon_read(mon_read),
        .mon_write(mon_write), .break_irq(break_irq)
    );

    function automatic int ign_bits(input logic [2:0] c);
        case (c)
            3'd0: return 0;  3'd1: return 1;  3'd2: return 2;  3'd3: return 4;
            3'd4: return 8;  3'd5: return 12; 3'd6: return 16; default: return 24;
        endcase
    endfunction

    function automatic logic model_hit(input int ch, input logic [23:0] a, input logic ms,
                                       input logic f, input logic r, input logic w);
        logic [23:0] care;
        logic        kind_ok;
        care = 24'hFFFFFF << ign_bits(m_ctrl[ch][5:3]);
        case (m_ctrl[ch][2:1])
            2'b00: kind_ok = f;
            2'b01: kind_ok = r;
            2'b10: kind_ok = w;
            default: kind_ok = r | w;
        endcase
        return (((m_bar[ch] ^ a) & care) == 24'h0) && kind_ok && (ms == m_ctrl[ch][6]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock cycle: optional register write plus one monitored bus cycle
    task automatic step(input logic we, input logic [1:0] ra, input logic [23:0] wd,
                        input logic [23:0] a, input logic ms,
                        input logic f, input logic r, input logic w);
        logic hit [2];
        reg_we = we; reg_addr = ra; reg_wdata = wd;
        mon_addr = a; mon_master = ms; mon_fetch = f; mon_read = r; mon_write = w;
        for (int c = 0; c < 2; c++) hit[c] = model_hit(c, a, ms, f, r, w);
        @(posedge clk);
        #5;
        for (int c = 0; c < 2; c++) begin
            if (we && ra == 2'(2 * c)) m_bar[c] = wd;
            if (we && ra == 2'(2 * c + 1)) begin
                m_ctrl[c] = wd[6:0];
                m_flag[c] = m_flag[c] & wd[7];
            end
            if (hit[c]) m_flag[c] = 1'b1;
            m_irq[c] = m_flag[c] & m_ctrl[c][0];
        end
        chk("R8/R9 irq vs model", {30'd0, break_irq}, {30'd0, m_irq[1], m_irq[0]});
        @(negedge clk);
        reg_we = 1'b0; mon_fetch = 1'b0; mon_read = 1'b0; mon_write = 1'b0;
    endtask

    task automatic wr(input logic [1:0] ra, input logic [23:0] wd);
        step(1'b1, ra, wd, 24'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic bus(input logic [23:0] a, input logic ms, input logic f,
                       input logic r, input logic w);
        step(1'b0, 2'd0, 24'h0, a, ms, f, r, w);
    endtask

    task automatic rd(input string req, input logic [1:0] ra, input logic [23:0] exp);
        reg_we = 1'b0; reg_addr = ra;
        #2;
        chk(req, {8'd0, reg_rdata}, {8'd0, exp});
    endtask

    function automatic logic [23:0] model_reg(input logic [1:0] ra);
        if (ra[0]) return {16'd0, m_flag[ra[1]], m_ctrl[ra[1]]};
        return m_bar[ra[1]];
    endfunction

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int c = 0; c < 2; c++) begin
            m_bar[c] = '0; m_ctrl[c] = '0; m_flag[c] = 1'b0; m_irq[c] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        for (int k = 0; k < 4; k++) rd("R1 reset reg", 2'(k), 24'h0);
        chk("R1 reset irq", {30'd0, break_irq}, 32'd0);

        // R2 read back
        wr(2'd0, 24'h123456);
        wr(2'd1, 24'h000001);
        rd("R2 bar A", 2'd0, 24'h123456);
        rd("R2 ctrl A", 2'd1, 24'h000001);

        // R6 no mask: neighbour address misses
        bus(24'h123457, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R6 no-mask miss", {30'd0, break_irq}, 32'd0);

        // R3 exact fetch hit
        bus(24'h123456, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3 fetch irq A", {30'd0, break_irq}, 32'd1);
        rd("R3 flag set", 2'd1, 24'h000081);

        // R7 write 1 keeps flag, write 0 clears
        wr(2'd1, 24'h000081);
        rd("R7 write1 keeps", 2'd1, 24'h000081);
        chk("R7 irq kept", {30'd0, break_irq}, 32'd1);
        wr(2'd1, 24'h000001);
        rd("R7 write0 clears", 2'd1, 24'h000001);
        chk("R7 irq cleared", {30'd0, break_irq}, 32'd0);

        // R6 mask code 3 (4 bits), R8 enable off still flags
        wr(2'd1, 24'h000018);
        bus(24'h12345F, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 no irq when disabled", {30'd0, break_irq}, 32'd0);
        rd("R6/R8 masked flag", 2'd1, 24'h000098);
        bus(24'h123466, 1'b0, 1'b1, 1'b0, 1'b0);
        wr(2'd1, 24'h000019);
        rd("R7 clear with enable", 2'd1, 24'h000019);

        // R5 master filter, R4 read condition, R9 independence
        wr(2'd2, 24'h00AB00);
        wr(2'd3, 24'h000043);
        bus(24'h00AB00, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5 wrong master", {30'd0, break_irq}, 32'd0);
        bus(24'h00AB00, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R4 fetch not read", {30'd0, break_irq}, 32'd0);
        bus(24'h00AB00, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R4/R9 read hit B only", {30'd0, break_irq}, 32'd2);
        rd("R9 A untouched", 2'd1, 24'h000019);

        // R4 write condition
        wr(2'd3, 24'h000045);
        bus(24'h00AB00, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R4 read not write", {30'd0, break_irq}, 32'd0);
        bus(24'h00AB00, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R4 write hit", {30'd0, break_irq}, 32'd2);
        wr(2'd3, 24'h000047);
        rd("R4 either cfg", 2'd3, 24'h000047);
        bus(24'h00AB00, 1'b1, 1'b0, 1'b1, 1'b0);
        rd("R4 either read hit", 2'd3, 24'h0000C7);

        // R6 mask code 7 ignores all 24 bits
        wr(2'd1, 24'h000039);
        bus(24'hFFFFFF, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R6 full mask hit", {31'd0, break_irq[0]}, 32'd1);

        // R7 set wins over a clearing write in the same cycle
        step(1'b1, 2'd1, 24'h000039, 24'h000000, 1'b0, 1'b1, 1'b0, 1'b0);
        rd("R7 set wins", 2'd1, 24'h0000B9);
        chk("R7 set wins irq", {31'd0, break_irq[0]}, 32'd1);

        // random run against the model
        for (int n = 0; n < 3000; n++) begin
            logic [23:0] a;
            int          pick;
            logic [1:0]  kind_sel;
            pick = $urandom_range(0, 1);
            a = ($urandom_range(0, 3) == 0) ? 24'($urandom)
                                            : (m_bar[pick] ^ 24'($urandom_range(0, 255)));
            kind_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0) begin
                logic [1:0]  ra;
                logic [23:0] wd;
                ra = 2'($urandom_range(0, 3));
                wd = ra[0] ? 24'($urandom_range(0, 255)) : 24'($urandom);
                step(1'b1, ra, wd, a, 1'($urandom), kind_sel == 1, kind_sel == 2, kind_sel == 3);
            end else begin
                step(1'b0, 2'd0, 24'h0, a, 1'($urandom), kind_sel == 1, kind_sel == 2, kind_sel == 3);
            end
            if (n % 4 == 0) begin
                logic [1:0] rra;
                rra = 2'($urandom_range(0, 3));
                rd("R2/R7 random readback", rra, model_reg(rra));
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule